// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block keeps the status byte of a serial nonvolatile memory and rules on every write that the serial engine wants to perform. The engine decodes opcodes and shifts data. This block receives the decoded strobes from it: set the write-enable latch, clear the latch, write-type opcode seen, select ended, a status write with its data byte, and a memory byte write with its 15-bit effective address. The block returns the status byte for reads and two permits that tell the engine whether the offered status byte or memory byte may be committed.

The status byte is laid out as follows:

| Bit | Meaning |
| --- | --- |
| 7 | Protect enable |
| 6..4 | Spare nonvolatile bits |
| 3..2 | Block-protect code |
| 1 | Write-enable latch |
| 0 | Always zero |

The nonvolatile bits are ordinary flops. They survive the end of a select period and return to zero only on power-up reset.

The two write offers (`sr_wr_valid_i` and `mem_wr_valid_i`) are qualified strobes, not handshakes. There is no back-pressure. A permit output is high in the same cycle as an allowed offer. When the permit is low, the engine must drop that byte rather than retry it.

Top module: `sreg_guard`

## Requirements
- R1: After power-up reset the status byte reads 0x00.
- R2: Bit 0 of the status byte always reads 0. A status write never changes bit 1 or bit 0; the data values offered for those bits are discarded.
- R3: A set-latch strobe makes bit 1 read 1 from the next cycle.
- R4: A clear-latch strobe makes bit 1 read 0 from the next cycle. When set and clear arrive in the same cycle, clear wins.
- R5: The latch is cleared when the select period ends, if a write-type opcode was seen in that period (including the ending cycle). A select period with no write-type opcode leaves the latch unchanged.
- R6: While the latch is 0, neither permit is ever asserted, and the status byte does not change on a status write offer.
- R7: With the latch at 1, a status write is permitted unless bit 7 is 1 and `wp_n_i` is low. A permitted write loads bits 7..2 from data bits 7..2 on the next cycle. A refused write leaves them unchanged.
- R8: The protected region comes from bits 3..2:
  - 00 protects nothing.
  - 01 protects 0x6000..0x7FFF.
  - 10 protects 0x4000..0x7FFF.
  - 11 protects 0x0000..0x7FFF.
  
  A memory byte offer is permitted exactly when the latch is 1 and its address lies outside the protected region.
- R9: Bits 6..4 are written by a permitted status write and read back unchanged.
- R10: The latch stays at 1 for every byte of a streamed memory write inside one select period, so each auto-incremented address is checked on its own.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low |
| set_wel_i | input | 1 | Set-latch command strobe |
| clr_wel_i | input | 1 | Clear-latch command strobe |
| wr_op_i | input | 1 | Status-write or memory-write opcode decoded |
| sel_end_i | input | 1 | Select period ends (chip select rises) |
| sr_wr_valid_i | input | 1 | Status data byte offered |
| sr_wr_data_i | input | 8 | Offered status byte |
| mem_wr_valid_i | input | 1 | Memory data byte offered |
| mem_wr_addr_i | input | 15 | Effective address of the offered byte |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte for reads |
| sr_wr_permit_o | output | 1 | Offered status byte may be committed |
| mem_wr_permit_o | output | 1 | Offered memory byte may be committed |

## Verification
The assertions assume that the engine produces strobes that are one cycle wide per event, and that it raises `sel_end_i` at most once per select period. They also assume the engine never offers a status byte and a memory byte in the same cycle. The stimulus drives each strobe for one cycle only, on the falling clock edge, and keeps the two data offers apart. It walks every block-protect code across the 0x3FFF/0x4000 and 0x5FFF/0x6000 boundaries and the array ends. It covers all eight combinations of latch, protect enable and pin level. A behavioural model in the bench is compared against the outputs on every cycle.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;
  localparam int STAT_W   = 8;
  localparam int NV_W     = 6;
  localparam int BP_W     = 2;
  localparam int SPARE_W  = 3;

  typedef struct packed {
    logic               wpen;
    logic [SPARE_W-1:0] spare;
    logic [BP_W-1:0]    bp;
  } nv_bits_t;

  typedef enum logic [BP_W-1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_code_e;

  function automatic nv_bits_t nv_from_byte(input logic [STAT_W-1:0] b);
    nv_bits_t r;
    r.wpen  = b[7];
    r.spare = b[6:4];
    r.bp    = b[3:2];
    return r;
  endfunction
endpackage

// File: rtl/sreg_guard_region.sv
module sreg_guard_region
  import sreg_guard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BP_W-1:0]   bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (bp_code_e'(bp_i))
      BP_NONE:    hit_o = 1'b0;
      BP_QUARTER: hit_o = addr_i[TOP] & addr_i[TOP-1];
      BP_HALF:    hit_o = addr_i[TOP];
      default:    hit_o = 1'b1;
    endcase
  end

  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_i == BP_ALL) |-> hit_o); // R8
  AST_NONE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_i == BP_NONE) |-> !hit_o); // R8
endmodule

// File: rtl/sreg_guard_store.sv
module sreg_guard_store
  import sreg_guard_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_wel_i,
  input  logic                clr_wel_i,
  input  logic                wr_op_i,
  input  logic                sel_end_i,
  input  logic                load_i,
  input  logic [STAT_W-1:0]   load_data_i,
  output nv_bits_t            nv_o,
  output logic                wel_o
);
  logic wr_seen_q;
  logic end_clear;

  assign end_clear = sel_end_i & (wr_seen_q | wr_op_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_o      <= '0;
      wel_o     <= 1'b0;
      wr_seen_q <= 1'b0;
    end else begin
      if (load_i) nv_o <= nv_from_byte(load_data_i);
      if (clr_wel_i || end_clear) wel_o <= 1'b0;
      else if (set_wel_i)         wel_o <= 1'b1;
      if (sel_end_i)    wr_seen_q <= 1'b0;
      else if (wr_op_i) wr_seen_q <= 1'b1;
    end
  end

  AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wel_i && !clr_wel_i && !sel_end_i) |=> wel_o); // R3
  AST_WEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wel_i |=> !wel_o); // R4
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end_i && wr_op_i) |=> !wel_o); // R5
endmodule

// File: rtl/sreg_guard_policy.sv
module sreg_guard_policy
  import sreg_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wel_i,
  input  logic wpen_i,
  input  logic wp_n_i,
  input  logic region_hit_i,
  input  logic sr_valid_i,
  input  logic mem_valid_i,
  output logic sr_permit_o,
  output logic mem_permit_o
);
  logic sr_locked;

  assign sr_locked    = wpen_i & ~wp_n_i;
  assign sr_permit_o  = sr_valid_i & wel_i & ~sr_locked;
  assign mem_permit_o = mem_valid_i & wel_i & ~region_hit_i;

  AST_NO_PERMIT_WEL0: assert property (@(posedge clk) disable iff (!rst_n)
    !wel_i |-> (!sr_permit_o && !mem_permit_o)); // R6
  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen_i && !wp_n_i) |-> !sr_permit_o); // R7
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              wr_op_i,
  input  logic              sel_end_i,
  input  logic              sr_wr_valid_i,
  input  logic [7:0]        sr_wr_data_i,
  input  logic              mem_wr_valid_i,
  input  logic [ADDR_W-1:0] mem_wr_addr_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              sr_wr_permit_o,
  output logic              mem_wr_permit_o
);
  nv_bits_t nv;
  logic     wel;
  logic     hit;

  sreg_guard_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_wel_i   (set_wel_i),
    .clr_wel_i   (clr_wel_i),
    .wr_op_i     (wr_op_i),
    .sel_end_i   (sel_end_i),
    .load_i      (sr_wr_permit_o),
    .load_data_i (sr_wr_data_i),
    .nv_o        (nv),
    .wel_o       (wel)
  );

  sreg_guard_region #(.ADDR_W(ADDR_W)) u_region (
    .clk    (clk),
    .rst_n  (rst_n),
    .bp_i   (nv.bp),
    .addr_i (mem_wr_addr_i),
    .hit_o  (hit)
  );

  sreg_guard_policy u_policy (
    .clk          (clk),
    .rst_n        (rst_n),
    .wel_i        (wel),
    .wpen_i       (nv.wpen),
    .wp_n_i       (wp_n_i),
    .region_hit_i (hit),
    .sr_valid_i   (sr_wr_valid_i),
    .mem_valid_i  (mem_wr_valid_i),
    .sr_permit_o  (sr_wr_permit_o),
    .mem_permit_o (mem_wr_permit_o)
  );

  assign status_o = {nv.wpen, nv.spare, nv.bp, wel, 1'b0};

  AST_SR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_permit_o |=> $stable(status_o[7:2])); // R7
  AST_SR_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_permit_o |=> (status_o[7:2] == $past(sr_wr_data_i[7:2]))); // R9
endmodule

// File: tb/tb_sreg_guard.sv
module tb_sreg_guard;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_wel = 0, clr_wel = 0, wr_op = 0, sel_end = 0;
  logic        sr_valid = 0, mem_valid = 0, wp_n = 1;
  logic [7:0]  sr_data = '0;
  logic [14:0] mem_addr = '0;
  logic [7:0]  status;
  logic        sr_permit, mem_permit;

  int checks = 0, fails = 0;

  // behavioural reference state
  int m_nv = 0;      // value of status bits 7..2 as byte with low bits 0
  int m_wel = 0;
  int m_seen = 0;

  sreg_guard dut (
    .clk(clk), .rst_n(rst_n), .set_wel_i(set_wel), .clr_wel_i(clr_wel),
    .wr_op_i(wr_op), .sel_end_i(sel_end), .sr_wr_valid_i(sr_valid),
    .sr_wr_data_i(sr_data), .mem_wr_valid_i(mem_valid),
    .mem_wr_addr_i(mem_addr), .wp_n_i(wp_n), .status_o(status),
    .sr_wr_permit_o(sr_permit), .mem_wr_permit_o(mem_permit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_status();
    return m_nv | (m_wel << 1);
  endfunction

  function automatic int exp_sr_permit();
    int wpen = (m_nv >> 7) & 1;
    if (!sr_valid || m_wel == 0) return 0;
    if (wpen == 1 && wp_n == 0) return 0;
    return 1;
  endfunction

  function automatic int exp_mem_permit();
    int bp = (m_nv >> 2) & 3;
    int a = int'(mem_addr);
    int lo;
    if (!mem_valid || m_wel == 0) return 0;
    case (bp)
      0: lo = 32768;
      1: lo = 'h6000;
      2: lo = 'h4000;
      default: lo = 0;
    endcase
    return (a >= lo) ? 0 : 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // inputs already driven after a falling edge; compare, then advance model at rising edge
  task automatic cycle(input string tag);
    int nsr;
    #1;
    chk({tag, " R2 R3 R4 R5 status"}, int'(status), exp_status());
    chk({tag, " R6 R7 sr permit"}, int'(sr_permit), exp_sr_permit());
    chk({tag, " R8 R10 mem permit"}, int'(mem_permit), exp_mem_permit());
    nsr = exp_sr_permit();
    @(posedge clk);
    if (nsr == 1) m_nv = int'(sr_data) & 'hFC;
    if (clr_wel || (sel_end && (m_seen == 1 || wr_op))) m_wel = 0;
    else if (set_wel) m_wel = 1;
    if (sel_end) m_seen = 0;
    else if (wr_op) m_seen = 1;
    @(negedge clk);
    set_wel = 0; clr_wel = 0; wr_op = 0; sel_end = 0;
    sr_valid = 0; mem_valid = 0;
  endtask

  task automatic do_set();  set_wel = 1; cycle("set");  endtask
  task automatic do_end();  sel_end = 1; cycle("end");  endtask

  task automatic do_srw(input logic [7:0] d, input logic pin);
    wp_n = pin; wr_op = 1; cycle("srw op");
    sr_valid = 1; sr_data = d; cycle("srw data");
    do_end();
  endtask

  task automatic do_memw(input logic [14:0] a);
    mem_valid = 1; mem_addr = a; cycle("memw");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset value
    chk("R1 reset status", int'(status), 0);
    rst_n = 1;
    @(negedge clk);
    cycle("idle");
    // R3, R4
    do_set();
    clr_wel = 1; cycle("clr");
    set_wel = 1; clr_wel = 1; cycle("set+clr R4");
    // R6: write offered with latch low is ignored
    do_srw(8'hFF, 1'b1);
    // R2 R9: permitted write, low bits discarded, spare bits read back
    do_set(); do_srw(8'hF3, 1'b1);
    do_set(); do_srw(8'h70, 1'b1);
    // R5: select end without write opcode keeps latch
    do_set(); do_end(); cycle("latch kept R5");
    clr_wel = 1; cycle("clr");
    // R8 R10: each block-protect code over boundary addresses, streamed
    for (int bp = 0; bp < 4; bp++) begin
      do_set(); do_srw(8'(bp << 2), 1'b1);
      do_set(); wr_op = 1; cycle("mem op");
      do_memw(15'h0000); do_memw(15'h3FFF); do_memw(15'h4000);
      do_memw(15'h5FFF); do_memw(15'h6000); do_memw(15'h7FFF);
      do_end();
      do_memw(15'h0001);
    end
    // R7: all eight combinations of latch, protect enable, pin
    for (int k = 0; k < 8; k++) begin
      logic wel_b = k[2];
      logic wpen_b = k[1];
      logic pin_b = k[0];
      do_set(); do_srw({wpen_b, 7'h00}, 1'b1);
      if (wel_b) do_set();
      wp_n = pin_b; wr_op = 1; cycle("combo op R7");
      sr_valid = 1; sr_data = {wpen_b, 3'b101, 4'b0000}; cycle("combo data R7");
      cycle("combo after R7");
      do_end();
    end
    // unlock for cleanliness
    wp_n = 1; do_set(); do_srw(8'h00, 1'b1);
    cycle("final");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule